// File: doc/BRIEF.md
# Responder Resolution and Selection Unit

This block sits beside a small array of processing elements, each of which owns a one-bit responder flag that says whether it matched the last associative search. A combinational prefix-OR chain runs across the array. It gives every PE a flag that tells it whether any PE with a lower index is a responder. The end of the chain is a global any-responder flag that goes to the control unit.

The same chain picks one responder: the PE whose own flag is set and whose lower neighbours are all clear. That PE is the lowest-index responder. A strobe with a two-bit opcode applies one of three selection modes to the responder vector. Step reports the winner and removes it from the set. Find reports the winner and leaves the set untouched. Resolve-first reports the winner and keeps only that PE. The result is registered and appears one cycle after the strobe. The control unit normally writes the returned vector back into the PE responder registers and feeds it in again for the next operation.

Top module: `rsp_resolver`

## Requirements
- R1: After reset, `rsp_out`, `sel_out`, `done` and `res_vld` are all zero.
- R2: `rsp_before[0]` is always 0. For i > 0, `rsp_before[i]` is the OR of `rsp_in[i-1:0]`. It is combinational, with no clock delay.
- R3: `any_rsp` is the OR of every bit of `rsp_in`. It is combinational.
- R4: One clock edge after a strobe (`op_vld`=1), `res_vld` is 1. For opcodes 0 to 2, `sel_out` is one-hot at the lowest-index set bit of the sampled `rsp_in`, or all zero when there is none.
- R5: Opcode 2'b00 (step) returns `rsp_out` equal to the sampled `rsp_in` with the selected bit cleared.
- R6: Opcode 2'b01 (find) returns `rsp_out` equal to the sampled `rsp_in`, with no bit changed.
- R7: Opcode 2'b10 (resolve-first) returns `rsp_out` equal to `sel_out`, so only the winner stays a responder.
- R8: For opcodes 0 to 2, `done` is 1 exactly when the sampled `rsp_in` is all zero. In that case `sel_out` and `rsp_out` are zero.
- R9: Opcode 2'b11 (hold) returns `rsp_out` equal to the sampled `rsp_in`, with `sel_out` zero and `done` 0.
- R10: A cycle without a strobe drives `res_vld` to 0 and leaves `rsp_out`, `sel_out` and `done` at their previous values, whatever `rsp_in` does.
- R11: Repeated steps, each fed with the previous `rsp_out`, report every original responder exactly once in ascending index order. They then report `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Operation strobe |
| op_code | input | 2 | 0 step, 1 find, 2 resolve-first, 3 hold |
| rsp_in | input | N_PE | Responder flags, one per PE |
| rsp_before | output | N_PE | Per-PE flag: some lower-index PE responds |
| any_rsp | output | 1 | At least one responder exists |
| rsp_out | output | N_PE | Updated responder vector (registered) |
| sel_out | output | N_PE | One-hot selected PE (registered) |
| done | output | 1 | No responder was present at the strobe (registered) |
| res_vld | output | 1 | Result of the previous strobe is on the outputs |

## Verification
Two things can happen in the same cycle. The registered result of one strobe appears on the outputs while the next strobe samples that very result as its input. At that moment the combinational chain and `any_rsp` already describe the new vector, while `sel_out` still describes the old one. The bench provokes this with back-to-back step and resolve-first loops, where each strobe reuses the previous `rsp_out`. At each edge it compares both views against models computed from the vector it drove: the chain flags before the edge, the selection after it.

// File: rtl/rsp_resolver.sv
module rsp_resolver #(
  parameter int N_PE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_vld,
  input  logic [1:0]      op_code,
  input  logic [N_PE-1:0] rsp_in,
  output logic [N_PE-1:0] rsp_before,
  output logic            any_rsp,
  output logic [N_PE-1:0] rsp_out,
  output logic [N_PE-1:0] sel_out,
  output logic            done,
  output logic            res_vld
);

  localparam logic [1:0] OP_STEP = 2'd0;
  localparam logic [1:0] OP_FIND = 2'd1;
  localparam logic [1:0] OP_RSLV = 2'd2;
  localparam logic [N_PE-1:0] ONE = {{(N_PE-1){1'b0}}, 1'b1};

  logic [N_PE:0]   chain;
  logic [N_PE-1:0] winner;
  logic [N_PE-1:0] nxt_rsp, nxt_sel;
  logic            nxt_done;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N_PE; i++) begin : g_chain
    assign chain[i+1] = chain[i] | rsp_in[i];
  end

  assign rsp_before = chain[N_PE-1:0];
  assign any_rsp    = chain[N_PE];
  assign winner     = rsp_in & ~rsp_before;

  always_comb begin
    nxt_sel  = winner;
    nxt_done = ~any_rsp;
    case (op_code)
      OP_STEP: nxt_rsp = rsp_in & ~winner;
      OP_FIND: nxt_rsp = rsp_in;
      OP_RSLV: nxt_rsp = winner;
      default: begin
        nxt_rsp  = rsp_in;
        nxt_sel  = '0;
        nxt_done = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_out <= '0;
      sel_out <= '0;
      done    <= 1'b0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= op_vld;
      if (op_vld) begin
        rsp_out <= nxt_rsp;
        sel_out <= nxt_sel;
        done    <= nxt_done;
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_out)); // R4

  AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_code != 2'd3 |=> sel_out == ($past(rsp_in) & (~$past(rsp_in) + ONE))); // R4

  AST_STEP_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_code == OP_STEP |=> ((rsp_out | sel_out) == $past(rsp_in)) && ((rsp_out & sel_out) == '0)); // R5

  AST_FIND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_code == OP_FIND |=> rsp_out == $past(rsp_in)); // R6

  AST_RSLV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_code == OP_RSLV |=> rsp_out == sel_out); // R7

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && op_code != 2'd3 |=> done == ($past(rsp_in) == '0)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> !res_vld && $stable(rsp_out) && $stable(sel_out) && $stable(done)); // R10

endmodule

// File: tb/rsp_resolver_tb.sv
`timescale 1ns/1ps
module rsp_resolver_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_vld = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic [N-1:0] rsp_in = '0;
  logic [N-1:0] rsp_before, rsp_out, sel_out;
  logic any_rsp, done, res_vld;

  int n_chk = 0;
  int n_fail = 0;
  logic [N-1:0] e_rsp = '0, e_sel = '0;
  logic e_done = 1'b0;

  always #2.5 clk = ~clk;

  rsp_resolver #(.N_PE(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
    .rsp_in(rsp_in), .rsp_before(rsp_before), .any_rsp(any_rsp),
    .rsp_out(rsp_out), .sel_out(sel_out), .done(done), .res_vld(res_vld)
  );

  function automatic logic [N-1:0] m_before(logic [N-1:0] v);
    logic [N-1:0] b = '0;
    for (int i = 1; i < N; i++) b[i] = b[i-1] | v[i-1];
    return b;
  endfunction

  function automatic logic [N-1:0] m_first(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] code, logic [N-1:0] v);
    logic [N-1:0] w;
    op_vld = 1'b1; op_code = code; rsp_in = v;
    #1;
    chk(rsp_before == m_before(v), "R2", 32'(rsp_before), 32'(m_before(v)));
    chk(any_rsp == (v != '0), "R3", 32'(any_rsp), 32'(v != '0));
    w = m_first(v);
    case (code)
      2'd0: begin e_rsp = v & ~w; e_sel = w; e_done = (v == '0); end
      2'd1: begin e_rsp = v;      e_sel = w; e_done = (v == '0); end
      2'd2: begin e_rsp = w;      e_sel = w; e_done = (v == '0); end
      default: begin e_rsp = v;   e_sel = '0; e_done = 1'b0; end
    endcase
    @(negedge clk);
    chk(res_vld == 1'b1, "R4", 32'(res_vld), 32'd1);
    chk(sel_out == e_sel, code == 2'd3 ? "R9" : "R4", 32'(sel_out), 32'(e_sel));
    chk(rsp_out == e_rsp, code == 2'd0 ? "R5" : code == 2'd1 ? "R6" : code == 2'd2 ? "R7" : "R9",
        32'(rsp_out), 32'(e_rsp));
    chk(done == e_done, code == 2'd3 ? "R9" : "R8", 32'(done), 32'(e_done));
  endtask

  task automatic idle(logic [N-1:0] v);
    op_vld = 1'b0; op_code = 2'($urandom); rsp_in = v;
    @(negedge clk);
    chk(res_vld == 1'b0, "R10", 32'(res_vld), 32'd0);
    chk(rsp_out == e_rsp, "R10", 32'(rsp_out), 32'(e_rsp));
    chk(sel_out == e_sel, "R10", 32'(sel_out), 32'(e_sel));
    chk(done == e_done, "R10", 32'(done), 32'(e_done));
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] v, seen;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(rsp_out == '0 && sel_out == '0 && !done && !res_vld, "R1",
        32'({rsp_out, sel_out, done, res_vld}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(2'd0, '0);
    apply(2'd1, '0);
    apply(2'd2, '0);
    apply(2'd0, N'(1) << (N-1));
    apply(2'd2, '1);
    apply(2'd1, '1);
    apply(2'd3, 8'hA5);
    idle(8'h3C);
    idle(8'h00);

    // R11: step loop, each strobe consuming the previous result back to back
    for (int t = 0; t < 20; t++) begin
      v = N'($urandom);
      seen = '0;
      apply(2'd0, v);
      for (int k = 0; k < N + 1; k++) begin
        if (done) break;
        chk(sel_out > seen, "R11", 32'(sel_out), 32'(seen));
        seen = seen | sel_out;
        apply(2'd0, rsp_out);
      end
      chk(seen == v && done, "R11", 32'(seen), 32'(v));
    end

    // resolve-first fed straight back keeps the same winner
    for (int t = 0; t < 10; t++) begin
      v = N'($urandom) | N'(1);
      apply(2'd2, v);
      apply(2'd2, rsp_out);
    end

    for (int t = 0; t < 400; t++) begin
      v = N'($urandom);
      if (($urandom % 4) == 0) idle(v);
      else apply(2'($urandom), v);
    end

    op_vld = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule